// File: doc/BRIEF.md
# Horizontal Drive and Clamp Pulse Generator

This block turns a free-running line position count into the per-line pulses of a horizontal deflection stage. It drives the line output transistor with a conducting window that opens at the start of each line. It places a clamp pulse a programmable distance after the line reference, and it marks where horizontal blanking begins ahead of the flyback centre. When the line drive is enabled, the conducting share starts small and grows linearly, one step per line, up to its steady value. This soft start protects the output stage at power-up.

The line position count comes from outside the block. It is 0 on the clock at which the line reference strobe is seen and wraps at the programmed line length. An overvoltage flag from the high-voltage sense path always raises a sticky protection status. A protect-mode input chooses whether the same flag also shuts the line drive off. A clamp-suppress control removes the clamp pulse while the deflection sequencer is in its wait, stop or protection state.

Top module: `hdrv_gen`

## Requirements
- R1: While rst_n is low and on the first clock after it, hout, clamp, hblank and prot are all 0.
- R2: While line_en is 0, hout is 0 (0 = not conducting, 1 = conducting).
- R3: Number the lines from the first line start (line_pos = 0) at which line_en is sampled 1. Line n then conducts for positions 0 .. L-1, where L = floor(K*(5*RAMP + 47*min(n,RAMP)) / (100*RAMP)), K = line_len and RAMP = ramp length in lines. hout reflects line_pos one clock later.
- R4: Once n reaches RAMP, every later line conducts for floor(K*52/100) clocks, i.e. 52% of the line.
- R5: A new conducting length is taken only at line_pos = 0. If line_en rises in mid-line, no conducting clock appears before the next line start.
- R6: clamp is high for exactly 21 consecutive positions, starting at line_pos = 35 + 2*clamp_shift (clamp_shift 3 bits, 35 to 49), one clock later.
- R7: With clamp_supp = 1 and seq_mode not run (encoding: 00 run, 01 wait, 10 stop, 11 protect), clamp stays 0. With clamp_supp = 0 or seq_mode = 00, clamp is produced normally.
- R8: With prot_drive = 1, an overvoltage sample forces hout to 0 from the clock it is sampled. hout stays 0 until line_en has been 0 and is set again, which restarts the soft start at n = 0.
- R9: With prot_drive = 0, an overvoltage sample leaves hout unchanged.
- R10: An overvoltage sample sets prot on the next clock whatever prot_drive is. prot stays 1 until a prot_ack clock with no overvoltage.
- R11: hblank is a one-clock pulse once per line at position (fb_centre - (K + 41 - 432)) mod K, one clock later. K must lie in 391..432.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | synchronous active-low reset |
| line_pos | input | 10 | clock position within the line, 0 at the line reference |
| line_len | input | 10 | clocks per line K |
| fb_centre | input | 10 | line position of the flyback centre |
| line_en | input | 1 | line drive start (1) / stop (0) |
| prot_drive | input | 1 | 1: overvoltage also shuts the drive off |
| ovp | input | 1 | overvoltage detected |
| prot_ack | input | 1 | clears the protection status |
| clamp_supp | input | 1 | suppress clamp outside run state |
| seq_mode | input | 2 | sequencer state: 00 run, 01 wait, 10 stop, 11 protect |
| clamp_shift | input | 3 | clamp position code |
| hout | output | 1 | line output drive, 1 = conducting |
| clamp | output | 1 | clamp pulse |
| hblank | output | 1 | horizontal blanking start strobe |
| prot | output | 1 | sticky overvoltage status |

## Verification
The bench builds the block with a soft-start length of 8 lines instead of 2000. The full ramp, its 52% plateau, a restart after a protective shutdown and mid-line enable changes then all fit in a few dozen real 432-clock lines. Conducting lengths are counted per line and compared with the ramp formula. The line length is also changed to 430 so that the blanking lead moves off its maximum of 41 clocks and the wrap around the line end is exercised.

// File: rtl/hdrv_pkg.sv
// Shared types for the horizontal drive generator.
package hdrv_pkg;
    // Deflection sequencer state as seen by this block.
    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_WAIT = 2'b01,
        MODE_STOP = 2'b10,
        MODE_PROT = 2'b11
    } hmode_e;
endpackage

// File: rtl/hdrv_guard.sv
// Overvoltage guard: keeps a trip latch that inhibits the drive until
// the line drive is stopped, and a sticky status flag cleared by an ack.
// Assumes ovp is already synchronous to clk.
module hdrv_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic line_en,
    input  logic prot_drive,
    input  logic ovp,
    input  logic prot_ack,
    output logic drive_ok,
    output logic prot
);
    logic trip_q;
    logic prot_q;

    // Trip latch: set by a drive-disabling overvoltage, released by a stop.
    always_ff @(posedge clk) begin
        if (!rst_n)            trip_q <= 1'b0;
        else if (!line_en)     trip_q <= 1'b0;
        else if (prot_drive && ovp) trip_q <= 1'b1;
    end

    // Status flag: any overvoltage sets it, an ack clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)        prot_q <= 1'b0;
        else if (ovp)      prot_q <= 1'b1;
        else if (prot_ack) prot_q <= 1'b0;
    end

    // Drive allowed unless tripped now or earlier.
    assign drive_ok = !(trip_q || (prot_drive && ovp));
    assign prot     = prot_q;
endmodule

// File: rtl/hdrv_ramp.sv
// Soft-start sequencer: steps the conducting length from the low to the
// high duty share over RAMP_LINES lines, updating only at line start.
// Assumes line_len stays constant while the drive runs.
module hdrv_ramp #(
    parameter int POS_W       = 10,
    parameter int RAMP_LINES  = 2000,
    parameter int DUTY_LO_PCT = 5,
    parameter int DUTY_HI_PCT = 52
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sol,
    input  logic [POS_W-1:0] line_len,
    input  logic             line_en,
    input  logic             drive_ok,
    output logic [POS_W-1:0] on_len
);
    localparam int STEP_W = $clog2(RAMP_LINES + 1);
    localparam int DEN    = 100 * RAMP_LINES;
    localparam int NUM_W  = $clog2(DEN + 1);
    localparam int PROD_W = POS_W + NUM_W;

    logic [STEP_W-1:0] step_q;
    logic [POS_W-1:0]  len_q;
    logic [NUM_W-1:0]  num;
    logic [PROD_W-1:0] prod;
    logic [POS_W-1:0]  len_calc;
    logic              run_now;

    // Duty numerator for the current step and the resulting clock count.
    always_comb begin
        num      = NUM_W'(DUTY_LO_PCT * RAMP_LINES)
                 + NUM_W'(DUTY_HI_PCT - DUTY_LO_PCT) * NUM_W'(step_q);
        prod     = PROD_W'(line_len) * PROD_W'(num);
        len_calc = POS_W'(prod / PROD_W'(DEN));
        run_now  = line_en && drive_ok;
    end

    // Step counter and latched length, advanced once per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            len_q  <= '0;
        end else if (!line_en) begin
            step_q <= '0;
            len_q  <= '0;
        end else if (sol) begin
            len_q <= run_now ? len_calc : '0;
            if (run_now && (step_q < STEP_W'(RAMP_LINES)))
                step_q <= step_q + 1'b1;
        end
    end

    // Length in force for the current position.
    assign on_len = sol ? (run_now ? len_calc : '0) : len_q;
endmodule

// File: rtl/hdrv_clamp.sv
// Clamp pulse placement: fixed-width window at a coded offset from the
// line reference, optionally removed outside the run state.
module hdrv_clamp #(
    parameter int POS_W      = 10,
    parameter int SHIFT_W    = 3,
    parameter int CLAMP_BASE = 35,
    parameter int CLAMP_STEP = 2,
    parameter int CLAMP_WID  = 21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [POS_W-1:0]   line_pos,
    input  logic [SHIFT_W-1:0] shift,
    input  logic               supp_en,
    input  hdrv_pkg::hmode_e   mode,
    output logic               clamp
);
    localparam int CW = POS_W + 1;

    logic [CW-1:0] c_start;
    logic [CW-1:0] c_end;
    logic          in_win;
    logic          suppress;

    // Window bounds and suppression decision.
    always_comb begin
        c_start  = CW'(CLAMP_BASE) + CW'(CLAMP_STEP) * CW'(shift);
        c_end    = c_start + CW'(CLAMP_WID);
        in_win   = (CW'(line_pos) >= c_start) && (CW'(line_pos) < c_end);
        suppress = supp_en && (mode != hdrv_pkg::MODE_RUN);
    end

    // Registered clamp output.
    always_ff @(posedge clk) begin
        if (!rst_n) clamp <= 1'b0;
        else        clamp <= in_win && !suppress;
    end
endmodule

// File: rtl/hdrv_blank.sv
// Horizontal blanking start: one-clock strobe ahead of the flyback centre
// by a lead that scales with the line length. Assumes
// NOM_LEN-LEAD_MAX <= line_len <= NOM_LEN and fb_centre < line_len.
module hdrv_blank #(
    parameter int POS_W    = 10,
    parameter int NOM_LEN  = 432,
    parameter int LEAD_MAX = 41
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] line_pos,
    input  logic [POS_W-1:0] line_len,
    input  logic [POS_W-1:0] fb_centre,
    output logic             hblank
);
    localparam int CW = POS_W + 1;

    logic [CW-1:0] lead;
    logic [CW-1:0] target;

    // Lead from line length, then target position with wrap.
    always_comb begin
        lead = CW'(line_len) + CW'(LEAD_MAX) - CW'(NOM_LEN);
        if (CW'(fb_centre) >= lead) target = CW'(fb_centre) - lead;
        else                        target = CW'(fb_centre) + CW'(line_len) - lead;
    end

    // Registered strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) hblank <= 1'b0;
        else        hblank <= (CW'(line_pos) == target);
    end
endmodule

// File: rtl/hdrv_gen.sv
// Horizontal drive and clamp generator top. Combines the soft-start
// sequencer, overvoltage guard, clamp placement and blanking strobe.
// All outputs are registered and reflect line_pos of the previous clock.
module hdrv_gen #(
    parameter int POS_W      = 10,
    parameter int RAMP_LINES = 2000,
    parameter int SHIFT_W    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [POS_W-1:0]   line_pos,
    input  logic [POS_W-1:0]   line_len,
    input  logic [POS_W-1:0]   fb_centre,
    input  logic               line_en,
    input  logic               prot_drive,
    input  logic               ovp,
    input  logic               prot_ack,
    input  logic               clamp_supp,
    input  logic [1:0]         seq_mode,
    input  logic [SHIFT_W-1:0] clamp_shift,
    output logic               hout,
    output logic               clamp,
    output logic               hblank,
    output logic               prot
);
    logic             sol;
    logic             drive_ok;
    logic [POS_W-1:0] on_len;

    assign sol = (line_pos == '0);

    hdrv_guard u_guard (
        .clk(clk), .rst_n(rst_n), .line_en(line_en), .prot_drive(prot_drive),
        .ovp(ovp), .prot_ack(prot_ack), .drive_ok(drive_ok), .prot(prot)
    );

    hdrv_ramp #(.POS_W(POS_W), .RAMP_LINES(RAMP_LINES)) u_ramp (
        .clk(clk), .rst_n(rst_n), .sol(sol), .line_len(line_len),
        .line_en(line_en), .drive_ok(drive_ok), .on_len(on_len)
    );

    hdrv_clamp #(.POS_W(POS_W), .SHIFT_W(SHIFT_W)) u_clamp (
        .clk(clk), .rst_n(rst_n), .line_pos(line_pos), .shift(clamp_shift),
        .supp_en(clamp_supp), .mode(hdrv_pkg::hmode_e'(seq_mode)), .clamp(clamp)
    );

    hdrv_blank #(.POS_W(POS_W)) u_blank (
        .clk(clk), .rst_n(rst_n), .line_pos(line_pos), .line_len(line_len),
        .fb_centre(fb_centre), .hblank(hblank)
    );

    // Line output drive: conducting window from line start.
    always_ff @(posedge clk) begin
        if (!rst_n) hout <= 1'b0;
        else        hout <= line_en && drive_ok && (line_pos < on_len);
    end
endmodule

// File: rtl/hdrv_gen_chk.sv
// Property checker for hdrv_gen, attached by bind.
module hdrv_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       line_en,
    input logic       prot_drive,
    input logic       ovp,
    input logic       clamp_supp,
    input logic [1:0] seq_mode,
    input logic       hout,
    input logic       clamp,
    input logic       hblank,
    input logic       prot
);
    // R2
    stop_hout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(line_en) |-> !hout);
    // R8
    trip_hout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(prot_drive && ovp) |-> !hout);
    // R7
    clamp_supp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clamp_supp && (seq_mode != 2'b00)) |-> !clamp);
    // R10
    prot_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovp) |-> prot);
    // R11
    hblank_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hblank |=> !hblank);
endmodule

bind hdrv_gen hdrv_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .prot_drive(prot_drive),
    .ovp(ovp), .clamp_supp(clamp_supp), .seq_mode(seq_mode),
    .hout(hout), .clamp(clamp), .hblank(hblank), .prot(prot)
);

// File: tb/hdrv_gen_tb.sv
module hdrv_gen_tb;
    localparam int RAMP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] line_pos = '0;
    logic [9:0] line_len = 10'd432;
    logic [9:0] fb_centre = 10'd300;
    logic       line_en = 1'b0;
    logic       prot_drive = 1'b0;
    logic       ovp = 1'b0;
    logic       prot_ack = 1'b0;
    logic       clamp_supp = 1'b0;
    logic [1:0] seq_mode = 2'b00;
    logic [2:0] clamp_shift = '0;
    logic       hout, clamp, hblank, prot;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    hdrv_gen #(.POS_W(10), .RAMP_LINES(RAMP)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_pos(line_pos), .line_len(line_len),
        .fb_centre(fb_centre), .line_en(line_en), .prot_drive(prot_drive),
        .ovp(ovp), .prot_ack(prot_ack), .clamp_supp(clamp_supp),
        .seq_mode(seq_mode), .clamp_shift(clamp_shift),
        .hout(hout), .clamp(clamp), .hblank(hblank), .prot(prot)
    );

    always #10 clk = ~clk;

    // clamp table: {shift[2:0], supp, mode[1:0], exp_start[7:0], exp_width[7:0]}
    localparam logic [21:0] CTAB [8] = '{
        {3'd0, 1'b0, 2'b00, 8'd35, 8'd21},
        {3'd3, 1'b0, 2'b01, 8'd41, 8'd21},
        {3'd7, 1'b0, 2'b11, 8'd49, 8'd21},
        {3'd5, 1'b1, 2'b00, 8'd45, 8'd21},
        {3'd2, 1'b1, 2'b01, 8'd0,  8'd0},
        {3'd4, 1'b1, 2'b10, 8'd0,  8'd0},
        {3'd6, 1'b1, 2'b11, 8'd0,  8'd0},
        {3'd1, 1'b0, 2'b10, 8'd37, 8'd21}
    };

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int k, input int n);
        int m = (n < RAMP) ? n : RAMP;
        return (k * (5 * RAMP + 47 * m)) / (100 * RAMP);
    endfunction

    // Runs one line; ovp pulsed at ovp_at, line_en raised at en_at (-1 = none).
    task automatic run_line(input int ovp_at, input int en_at,
                            output int hcnt, output int hfirst_off,
                            output int cfirst, output int cwid, output int hbpos,
                            output int hbcnt);
        hcnt = 0; hfirst_off = -1; cfirst = -1; cwid = 0; hbpos = -1; hbcnt = 0;
        for (int p = 0; p < int'(line_len); p++) begin
            line_pos = 10'(p);
            ovp = (p == ovp_at);
            if (p == en_at) line_en = 1'b1;
            @(posedge clk); #1;
            if (hout) hcnt++;
            else if (hfirst_off < 0) hfirst_off = p;
            if (clamp) begin
                if (cfirst < 0) cfirst = p;
                cwid++;
            end
            if (hblank) begin hbpos = p; hbcnt++; end
        end
        ovp = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int hc, hoff, cf, cw, hp, hn;
        repeat (3) @(posedge clk);
        #1;
        // R1 during reset
        check("R1 hout", hout, 0);
        check("R1 clamp", clamp, 0);
        check("R1 prot", prot, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 hblank", hblank, 0);

        // R2, R11: drive stopped, blanking at 300-41
        run_line(-1, -1, hc, hoff, cf, cw, hp, hn);
        check("R2 hout count", hc, 0);
        check("R11 hblank pos", hp, 259);
        check("R11 hblank count", hn, 1);

        // R6, R7 clamp table
        foreach (CTAB[i]) begin
            clamp_shift = CTAB[i][21:19];
            clamp_supp  = CTAB[i][18];
            seq_mode    = CTAB[i][17:16];
            run_line(-1, -1, hc, hoff, cf, cw, hp, hn);
            if (CTAB[i][7:0] == 8'd0) begin
                check("R7 clamp suppressed", cw, 0);
            end else begin
                check("R6 clamp start", cf, int'(CTAB[i][15:8]));
                check("R6 clamp width", cw, int'(CTAB[i][7:0]));
            end
        end
        clamp_supp = 1'b0; seq_mode = 2'b00;

        // R3, R4 soft start and plateau
        line_en = 1'b1;
        for (int n = 0; n < RAMP + 3; n++) begin
            run_line(-1, -1, hc, hoff, cf, cw, hp, hn);
            check((n < RAMP) ? "R3 ramp length" : "R4 plateau length", hc, exp_len(432, n));
            check("R3 window at line start", hoff, exp_len(432, n));
        end
        check("R4 52 percent", exp_len(432, RAMP), 224);

        // R5 mid-line enable
        line_en = 1'b0;
        run_line(-1, -1, hc, hoff, cf, cw, hp, hn);
        check("R2 stopped", hc, 0);
        run_line(-1, 100, hc, hoff, cf, cw, hp, hn);
        check("R5 no pulse after mid-line enable", hc, 0);
        run_line(-1, -1, hc, hoff, cf, cw, hp, hn);
        check("R5 first full line", hc, exp_len(432, 0));

        // R9, R10: status only
        prot_drive = 1'b0;
        run_line(50, -1, hc, hoff, cf, cw, hp, hn);
        check("R9 hout unaffected", hc, exp_len(432, 1));
        check("R10 prot set", prot, 1);
        prot_ack = 1'b1;
        @(posedge clk); #1;
        prot_ack = 1'b0;
        check("R10 prot cleared", prot, 0);

        // R8 drive shutdown, latch, restart
        prot_drive = 1'b1;
        run_line(10, -1, hc, hoff, cf, cw, hp, hn);
        check("R8 hout cut at ovp", hc, 10);
        check("R10 prot with drive off", prot, 1);
        run_line(-1, -1, hc, hoff, cf, cw, hp, hn);
        check("R8 held off", hc, 0);
        line_en = 1'b0;
        run_line(-1, -1, hc, hoff, cf, cw, hp, hn);
        line_en = 1'b1;
        run_line(-1, -1, hc, hoff, cf, cw, hp, hn);
        check("R8 ramp restarts", hc, exp_len(432, 0));
        run_line(-1, -1, hc, hoff, cf, cw, hp, hn);
        check("R8 ramp second step", hc, exp_len(432, 1));

        // R11 shorter line: lead 39, wraps
        line_en = 1'b0;
        line_len = 10'd430;
        fb_centre = 10'd20;
        run_line(-1, -1, hc, hoff, cf, cw, hp, hn);
        check("R11 wrapped pos", hp, 411);
        check("R11 wrapped count", hn, 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule